// File: doc/BRIEF.md
# Converter Position Output Interface

This block is the parallel read-out stage of a tracking angle converter. It takes the converter's 16-bit position count and reduces it to a programmable resolution by forcing unused low-order bits to zero in pairs. In a linear-displacement mode it shifts the count down by two places, so that the third bit from the top becomes the most significant bit. The result goes into an output latch. A host can freeze the latch while it reads. The latched word is presented on a shared bus as two byte lanes, and each lane has its own active-low enable.

The bus tri-state is modelled as one output-enable flag per byte lane. A lane that is not enabled also drives its data bits to zero. Resolution code and mode are sampled on the clock edge. The position count flows through the latch on every clock edge while the latch is transparent.

Bit numbering in the requirements counts from the most significant end. Bit 1 is `dataOut[15]` and bit 16 is `dataOut[0]`.

Top module: `posif_out`

## Requirements
- R1: In angle mode (`dispMode`=0), `resCode` 2'b00, 2'b01, 2'b10 and 2'b11 keep the top 10, 12, 14 and 16 bits of `posWord`. All lower bits of the latched word are 0.
- R2: In displacement mode (`dispMode`=1), bits 1 and 2 (`dataOut[15:14]`) are 0. `posWord[15:2]` is placed in `dataOut[13:0]`. Codes 2'b00, 2'b01, 2'b10 and 2'b11 then keep 8, 10, 12 and 14 bits counted from bit 3, and all lower bits are 0.
- R3: Reset clears the latched word to 0 and selects angle mode at 16 bits. The first load after reset uses that setting, whatever the inputs held during reset.
- R4: While `inhibitN` is 0 at a clock edge, the latched word keeps its value. Changes to the position, code or mode have no effect on it.
- R5: While `inhibitN` is 1, the latch loads the masked position at each clock edge. A new `posWord` therefore appears on `dataOut` one cycle later.
- R6: A change of `resCode` or `dispMode` is registered at one edge. It is applied to the load at the following edge, so it becomes visible two cycles after it is driven.
- R7: `byteEnN[1]` (active low) enables the upper lane, bits 1 to 8 (`dataOut[15:8]`). `byteEnN[0]` enables the lower lane, bits 9 to 16 (`dataOut[7:0]`). An enabled lane raises its `dataOe` bit and carries the latched byte. The two lanes act independently.
- R8: A lane whose enable is 1 drives its `dataOe` bit to 0 and its data bits to 0. The enables do not affect the latched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| posWord | input | 16 | Raw position count from the tracking loop |
| resCode | input | 2 | Resolution select code |
| dispMode | input | 1 | 1 selects linear-displacement mapping |
| inhibitN | input | 1 | 0 freezes the output latch, 1 makes it transparent |
| byteEnN | input | 2 | Active-low lane enables; [1] is the upper byte |
| dataOut | output | 16 | Parallel data, per-lane gated |
| dataOe | output | 2 | Per-lane output-enable flags (tri-state model) |

## Verification
The bench builds the block with its default 16-bit word and 8-bit lanes, so only eight resolution settings exist, two modes by four codes. It visits all eight settings, with several hundred pseudo-random words for each. Expected words come from the shift-and-mask arithmetic of R1 and R2. Because the configuration space is small, the bench can also walk all four enable combinations and test hold, reset default and the two-cycle configuration latency directly.

// File: rtl/posif_pkg.sv
package posif_pkg;
  localparam int CODE_W = 2;

  typedef struct packed {
    logic              loadEn;
    logic              dispSel;
    logic [CODE_W-1:0] widthCode;
  } posif_strobe_t;
endpackage

// File: rtl/posif_ctrl.sv
module posif_ctrl
  import posif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] resCode,
  input  logic              dispMode,
  input  logic              inhibitN,
  output posif_strobe_t     strobes
);
  logic [CODE_W-1:0] codeQ;
  logic              dispQ;

  // Configuration is registered; reset default is full width, angle mode.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= '1;
      dispQ <= 1'b0;
    end else begin
      codeQ <= resCode;
      dispQ <= dispMode;
    end
  end

  always_comb begin
    strobes.loadEn    = inhibitN;
    strobes.dispSel   = dispQ;
    strobes.widthCode = codeQ;
  end
endmodule

// File: rtl/posif_datapath.sv
module posif_datapath
  import posif_pkg::*;
#(
  parameter int POS_W      = 16,
  parameter int BYTE_W     = 8,
  parameter int DISP_SHIFT = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [POS_W-1:0]          posWord,
  input  posif_strobe_t             strobes,
  input  logic [POS_W/BYTE_W-1:0]   byteEnN,
  output logic [POS_W-1:0]          heldWord,
  output logic [POS_W-1:0]          dataOut,
  output logic [POS_W/BYTE_W-1:0]   dataOe
);
  localparam int NUM_LANES = POS_W / BYTE_W;
  localparam int MAX_CODE  = (1 << CODE_W) - 1;
  localparam int DISP_W    = POS_W - DISP_SHIFT;

  logic [POS_W-1:0] srcWord;
  logic [POS_W-1:0] keepMask;
  logic [POS_W-1:0] maskedWord;

  // Pair masking: each step below the top code removes two more low bits.
  always_comb begin
    int pairsOff;
    int keepW;
    pairsOff = MAX_CODE - int'(strobes.widthCode);
    if (strobes.dispSel) begin
      keepW   = DISP_W - 2 * pairsOff;
      srcWord = posWord >> DISP_SHIFT;
      for (int i = 0; i < POS_W; i++)
        keepMask[i] = (i < DISP_W) && (i >= DISP_W - keepW);
    end else begin
      keepW   = POS_W - 2 * pairsOff;
      srcWord = posWord;
      for (int i = 0; i < POS_W; i++)
        keepMask[i] = (i >= POS_W - keepW);
    end
    maskedWord = srcWord & keepMask;
  end

  // Output latch: transparent when loadEn is set, holds otherwise.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      heldWord <= '0;
    else if (strobes.loadEn)
      heldWord <= maskedWord;
  end

  // Byte lanes; lane NUM_LANES-1 carries the most significant byte.
  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    assign dataOe[g] = ~byteEnN[g];
    assign dataOut[g*BYTE_W +: BYTE_W] =
      byteEnN[g] ? '0 : heldWord[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/posif_out.sv
module posif_out
  import posif_pkg::*;
#(
  parameter int POS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [POS_W-1:0]        posWord,
  input  logic [CODE_W-1:0]       resCode,
  input  logic                    dispMode,
  input  logic                    inhibitN,
  input  logic [POS_W/BYTE_W-1:0] byteEnN,
  output logic [POS_W-1:0]        dataOut,
  output logic [POS_W/BYTE_W-1:0] dataOe
);
  posif_strobe_t    strobes;
  logic [POS_W-1:0] heldWord;

  posif_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .resCode  (resCode),
    .dispMode (dispMode),
    .inhibitN (inhibitN),
    .strobes  (strobes)
  );

  posif_datapath #(
    .POS_W  (POS_W),
    .BYTE_W (BYTE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .posWord  (posWord),
    .strobes  (strobes),
    .byteEnN  (byteEnN),
    .heldWord (heldWord),
    .dataOut  (dataOut),
    .dataOe   (dataOe)
  );
endmodule

// File: rtl/posif_checker.sv
module posif_checker
  import posif_pkg::*;
#(
  parameter int POS_W  = 16,
  parameter int BYTE_W = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [CODE_W-1:0]       resCode,
  input logic                    dispMode,
  input logic                    inhibitN,
  input logic [POS_W/BYTE_W-1:0] byteEnN,
  input logic [POS_W-1:0]        heldWord,
  input logic [POS_W-1:0]        dataOut,
  input logic [POS_W/BYTE_W-1:0] dataOe
);
  localparam int NUM_LANES = POS_W / BYTE_W;
  localparam int MAX_CODE  = (1 << CODE_W) - 1;
  localparam int ANG_MIN   = POS_W - 2 * MAX_CODE;

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !inhibitN |=> $stable(heldWord)); // R4

  AST_DISP_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && inhibitN && $past(dispMode) |=> heldWord[POS_W-1 -: 2] == 2'b00); // R2

  AST_NARROW_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && inhibitN && $past(resCode) == '0 && !$past(dispMode)
      |=> heldWord[POS_W-ANG_MIN-1:0] == '0); // R1

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLaneChk
    AST_LANE_OFF: assert property (@(posedge clk) disable iff (!rstN)
      byteEnN[g] |-> !dataOe[g] && dataOut[g*BYTE_W +: BYTE_W] == '0); // R8
    AST_LANE_ON: assert property (@(posedge clk) disable iff (!rstN)
      !byteEnN[g] |-> dataOe[g] && dataOut[g*BYTE_W +: BYTE_W] == heldWord[g*BYTE_W +: BYTE_W]); // R7
  end
endmodule

bind posif_out posif_checker #(.POS_W(POS_W), .BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .resCode  (resCode),
  .dispMode (dispMode),
  .inhibitN (inhibitN),
  .byteEnN  (byteEnN),
  .heldWord (heldWord),
  .dataOut  (dataOut),
  .dataOe   (dataOe)
);

// File: tb/sim_posif_out.sv
module sim_posif_out;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] posWord = 16'hFFFF;
  logic [1:0]  resCode = 2'b00;
  logic        dispMode = 1'b0;
  logic        inhibitN = 1'b1;
  logic [1:0]  byteEnN = 2'b11;
  logic [15:0] dataOut;
  logic [1:0]  dataOe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  posif_out u0 (
    .clk(clk), .rstN(rstN), .posWord(posWord), .resCode(resCode),
    .dispMode(dispMode), .inhibitN(inhibitN), .byteEnN(byteEnN),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  function automatic logic [15:0] expWord(logic [15:0] p, logic d, logic [1:0] c);
    int pairs = 3 - int'(c);
    int w;
    int v;
    int m;
    if (d) begin
      w = 14 - 2 * pairs;
      v = int'(p) >> 2;
      m = ((1 << w) - 1) << (14 - w);
    end else begin
      w = 16 - 2 * pairs;
      v = int'(p);
      m = ((1 << w) - 1) << (16 - w);
    end
    return 16'(v & m);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [15:0] held;
    // R3: reset clears latch; lanes off while enables idle high
    tick(2);
    chk("R8 reset oe", {30'd0, dataOe}, 32'd0);
    byteEnN = 2'b00;
    #1;
    chk("R3 reset latch", {16'd0, dataOut}, 32'd0);
    rstN = 1'b1;
    tick(1);
    chk("R3 default 16b", {16'd0, dataOut}, 32'h0000FFFF);
    tick(1);
    chk("R1 code00 after reset", {16'd0, dataOut}, 32'h0000FFC0);

    // R1/R2/R5: sweep all modes and codes with pseudo-random words
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 4; c++) begin
        dispMode = d[0];
        resCode = c[1:0];
        tick(2);
        for (int k = 0; k < 300; k++) begin
          posWord = 16'($urandom);
          if (k == 0) posWord = 16'hFFFF;
          tick(1);
          chk(d ? "R2 disp map" : "R1 angle mask", {16'd0, dataOut},
              {16'd0, expWord(posWord, d[0], c[1:0])});
        end
      end
    end

    // R6: configuration latency of two cycles
    dispMode = 1'b0; resCode = 2'b11; posWord = 16'hA5C3;
    tick(3);
    resCode = 2'b00;
    tick(1);
    chk("R6 old code still", {16'd0, dataOut}, 32'h0000A5C3);
    tick(1);
    chk("R6 new code applied", {16'd0, dataOut}, 32'h0000A5C0);
    dispMode = 1'b1; resCode = 2'b11;
    tick(1);
    chk("R6 mode old", {16'd0, dataOut}, 32'h0000A5C0);
    tick(1);
    chk("R6 mode new", {16'd0, dataOut}, {16'd0, expWord(16'hA5C3, 1'b1, 2'b11)});

    // R4: inhibit holds against position and config changes
    held = dataOut;
    inhibitN = 1'b0;
    posWord = 16'h1234; resCode = 2'b01; dispMode = 1'b0;
    tick(4);
    chk("R4 hold", {16'd0, dataOut}, {16'd0, held});
    posWord = 16'hFEDC;
    tick(2);
    chk("R4 hold2", {16'd0, dataOut}, {16'd0, held});
    inhibitN = 1'b1;
    tick(1);
    chk("R5 release", {16'd0, dataOut}, {16'd0, expWord(16'hFEDC, 1'b0, 2'b01)});

    // R7/R8: every enable combination
    resCode = 2'b11; posWord = 16'h9E71;
    tick(3);
    for (int e = 0; e < 4; e++) begin
      byteEnN = e[1:0];
      #1;
      chk("R7 oe", {30'd0, dataOe}, {30'd0, ~e[1:0]});
      chk(e[1] ? "R8 upper off" : "R7 upper on", {24'd0, dataOut[15:8]},
          e[1] ? 32'd0 : 32'h9E);
      chk(e[0] ? "R8 lower off" : "R7 lower on", {24'd0, dataOut[7:0]},
          e[0] ? 32'd0 : 32'h71);
    end
    // R8: enables leave the latched word untouched
    byteEnN = 2'b11;
    tick(2);
    byteEnN = 2'b00;
    #1;
    chk("R8 latch kept", {16'd0, dataOut}, 32'h00009E71);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule